// File: doc/BRIEF.md
# Conversion Oversampling Averager

This block sits between an analog-to-digital converter's result port and the register that holds the final result. When oversampling is on, it gathers a run of conversions of one channel, where the run length is a power of two. It adds them in a wide accumulator, shifts the total right by a separately chosen amount and delivers one averaged word with a one-cycle valid pulse. It also drives the converter's start line: it asks for each conversion it still needs, and it either chains those requests on its own or waits for a fresh trigger before each one.

When oversampling is off, the block is transparent. Every trigger becomes a conversion request one cycle later, and every returned sample appears on the output one cycle after it arrives, zero-extended. The ratio, shift and mode inputs are sampled at the trigger that opens a run. Changing them mid-run has no effect until the next run starts.

The controller has three states. IDLE waits for a trigger. WAIT waits for the converter to return a sample. HOLD, used only in per-sample mode, waits for the trigger that releases the next conversion. The transitions are:

- IDLE to WAIT when a trigger arrives while enabled (a request is issued).
- WAIT to IDLE when the final sample of the run is taken (the result is emitted).
- WAIT to WAIT when a non-final sample is taken in burst mode (the next request is chained).
- WAIT to HOLD when a non-final sample is taken in per-sample mode.
- HOLD to WAIT when a trigger arrives (a request is issued).
- Any state to IDLE whenever the enable is low.

Top module: `ovs_accum`

## Requirements
- R1: After reset, conv_req and avg_valid are low and avg_data is zero.
- R2: With cfg_en low, a trigger raises conv_req in the following cycle, and each sample raises avg_valid in the following cycle with avg_data equal to the sample zero-extended to 16 bits.
- R3: With cfg_en high, ratio code c (0..7) takes exactly 2^(c+1) samples per run and gives exactly one avg_valid pulse, in the cycle after the last sample is taken.
- R4: Shift codes 0 to 8 shift the sum right by that many bits; codes 9 to 15 act as 8.
- R5: The sum is held in 20 bits without overflow, and avg_data is the low 16 bits of the shifted sum with no rounding (256 samples of 4095 with shift 0 give 65280).
- R6: In burst mode (cfg_per_sample = 0), a single trigger starts the run, and conv_req is raised on its own in the cycle after each non-final sample, for a total of 2^(c+1) requests.
- R7: In per-sample mode (cfg_per_sample = 1), every conversion of the run, including the first, needs its own trigger, and conv_req follows each such trigger by one cycle.
- R8: While enabled and waiting for a sample, triggers are ignored and produce no conv_req.
- R9: While enabled, samples that arrive when no conversion is outstanding (in IDLE or HOLD) are not added to the sum.
- R10: Dropping cfg_en mid-run discards the partial sum and emits no averaged result for that run; the next run starts from zero.
- R11: Ratio, shift and mode are captured at the trigger that starts a run, and later changes to them do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Oversampling on (1) or pass-through (0) |
| cfg_ratio | input | 3 | Ratio code c; the run length is 2^(c+1) |
| cfg_shift | input | 4 | Right shift of the sum; values above 8 are clamped to 8 |
| cfg_per_sample | input | 1 | 0: one trigger per run; 1: one trigger per sample |
| trig_in | input | 1 | Conversion trigger |
| smp_valid | input | 1 | Converter result strobe |
| smp_data | input | 12 | Converter result |
| conv_req | output | 1 | Request to start a conversion |
| avg_valid | output | 1 | One-cycle strobe for avg_data |
| avg_data | output | 16 | Averaged result, or the passed-through sample |

## Verification
The bench goes after these corner cases:

- A full run of 256 maximum-value samples with no shift. A narrow accumulator or a rounding step would return something other than 65280.
- Shift codes above 8. An unclamped shift would read back near zero.
- Extra triggers while a conversion is outstanding, and stray samples between per-sample triggers. A design that honours them would give the wrong request count or add 4095 into the sum.
- A run abandoned by clearing the enable, and a run whose configuration changes right after its trigger. A design that keeps the partial sum, or follows the live configuration, would give a wrong average or hang waiting for a trigger that never comes.

Randomised runs across ratios, shifts and both modes are compared against a sum computed in the bench.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_HOLD = 2'd2
    } ovs_state_e;
endpackage

// File: rtl/ovs_seq.sv
module ovs_seq
    import ovs_pkg::*;
#(
    parameter int RCODE_W = 3,
    parameter int SCODE_W = 4,
    parameter int CNT_W   = 8,
    parameter int SH_W    = 4,
    parameter int MAX_SH  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               trig_i,
    input  logic               smp_valid_i,
    input  logic [RCODE_W-1:0] rcode_i,
    input  logic [SCODE_W-1:0] scode_i,
    input  logic               per_smp_i,
    output logic               conv_req_o,
    output logic               add_o,
    output logic               fin_o,
    output logic               clr_o,
    output logic [SH_W-1:0]    shift_o
);
    localparam int RMAX = CNT_W - 1;

    ovs_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, last_q;
    logic [SH_W-1:0]    shift_q;
    logic               per_q;
    logic               start, resume, take, fin;

    function automatic logic [CNT_W-1:0] last_index(input logic [RCODE_W-1:0] code);
        return {CNT_W{1'b1}} >> (RMAX - int'(code));
    endfunction

    function automatic logic [SH_W-1:0] clamp_shift(input logic [SCODE_W-1:0] code);
        if (int'(code) > MAX_SH) return SH_W'(MAX_SH);
        return SH_W'(code);
    endfunction

    assign start  = en_i && (state_q == S_IDLE) && trig_i;
    assign resume = en_i && (state_q == S_HOLD) && trig_i;
    assign take   = en_i && (state_q == S_WAIT) && smp_valid_i;
    assign fin    = take && (cnt_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_WAIT;
            S_WAIT: if (take) begin
                if (fin)        state_d = S_IDLE;
                else if (per_q) state_d = S_HOLD;
                else            state_d = S_WAIT;
            end
            S_HOLD: if (resume) state_d = S_WAIT;
            default: state_d = S_IDLE;
        endcase
        if (!en_i) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     conv_req_o <= 1'b0;
        else if (!en_i) conv_req_o <= trig_i;
        else            conv_req_o <= start || resume || (take && !fin && !per_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            last_q  <= '0;
            shift_q <= '0;
            per_q   <= 1'b0;
        end else if (!en_i) begin
            cnt_q   <= '0;
        end else if (start) begin
            cnt_q   <= '0;
            last_q  <= last_index(rcode_i);
            shift_q <= clamp_shift(scode_i);
            per_q   <= per_smp_i;
        end else if (take) begin
            cnt_q   <= fin ? '0 : cnt_q + 1'b1;
        end
    end

    assign add_o   = take;
    assign fin_o   = fin;
    assign clr_o   = !en_i || fin;
    assign shift_o = shift_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != S_IDLE |-> cnt_q <= last_q); // R3
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == S_IDLE); // R10
    AST_WAIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && state_q == S_WAIT && !smp_valid_i |=> !conv_req_o); // R8
    AST_HOLD_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && state_q == S_HOLD && !trig_i |=> !conv_req_o); // R7
endmodule

// File: rtl/ovs_acc.sv
module ovs_acc #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ACC_W-1:0]  sum_o
);
    logic [ACC_W-1:0] acc_q;

    assign sum_o = acc_q + ACC_W'(data_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (add_i) acc_q <= sum_o;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        add_i |-> sum_o >= acc_q); // R5
endmodule

// File: rtl/ovs_scale.sv
module ovs_scale #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 20,
    parameter int OUT_W  = 16,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fin_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic [ACC_W-1:0]  sum_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic              avg_valid_o,
    output logic [OUT_W-1:0]  avg_data_o
);
    logic [ACC_W-1:0] shifted;

    assign shifted = sum_i >> shift_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_valid_o <= 1'b0;
            avg_data_o  <= '0;
        end else if (!en_i) begin
            avg_valid_o <= smp_valid_i;
            if (smp_valid_i) avg_data_o <= OUT_W'(smp_data_i);
        end else begin
            avg_valid_o <= fin_i;
            if (fin_i) avg_data_o <= shifted[OUT_W-1:0];
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && smp_valid_i |=> avg_valid_o && avg_data_o == OUT_W'($past(smp_data_i))); // R2
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !fin_i |=> !avg_valid_o); // R3
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
    parameter int DATA_W  = 12,
    parameter int OUT_W   = 16,
    parameter int RCODE_W = 3,
    parameter int SCODE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [RCODE_W-1:0] cfg_ratio,
    input  logic [SCODE_W-1:0] cfg_shift,
    input  logic               cfg_per_sample,
    input  logic               trig_in,
    input  logic               smp_valid,
    input  logic [DATA_W-1:0]  smp_data,
    output logic               conv_req,
    output logic               avg_valid,
    output logic [OUT_W-1:0]   avg_data
);
    localparam int MAX_LOG2 = 1 << RCODE_W;
    localparam int ACC_W    = DATA_W + MAX_LOG2;
    localparam int CNT_W    = MAX_LOG2;
    localparam int MAX_SH   = MAX_LOG2;
    localparam int SH_W     = $clog2(MAX_SH + 1);

    logic             add, fin, clr;
    logic [SH_W-1:0]  shift;
    logic [ACC_W-1:0] sum;

    ovs_seq #(
        .RCODE_W(RCODE_W), .SCODE_W(SCODE_W), .CNT_W(CNT_W),
        .SH_W(SH_W), .MAX_SH(MAX_SH)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(cfg_en), .trig_i(trig_in),
        .smp_valid_i(smp_valid), .rcode_i(cfg_ratio), .scode_i(cfg_shift),
        .per_smp_i(cfg_per_sample), .conv_req_o(conv_req), .add_o(add),
        .fin_o(fin), .clr_o(clr), .shift_o(shift)
    );

    ovs_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .add_i(add),
        .data_i(smp_data), .sum_o(sum)
    );

    ovs_scale #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .en_i(cfg_en), .fin_i(fin),
        .smp_valid_i(smp_valid), .smp_data_i(smp_data), .sum_i(sum),
        .shift_i(shift), .avg_valid_o(avg_valid), .avg_data_o(avg_data)
    );
endmodule

// File: tb/ovs_accum_bench.sv
`timescale 1ns/1ps
module ovs_accum_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_per_sample = 1'b0, trig_in = 1'b0;
    logic [2:0]  cfg_ratio = '0;
    logic [3:0]  cfg_shift = '0;
    logic        cm_valid = 1'b0, sp_valid = 1'b0;
    logic [11:0] cm_data = '0, sp_data = '0;
    logic        smp_valid, conv_req, avg_valid;
    logic [11:0] smp_data;
    logic [15:0] avg_data, last_out;
    int          n_cmp = 0, n_bad = 0, req_cnt = 0, out_cnt = 0, cm_cnt = 0;
    longint      bsum = 0;
    bit          force_max = 1'b0;

    always #2.5 clk = ~clk;

    assign smp_valid = cm_valid | sp_valid;
    assign smp_data  = sp_valid ? sp_data : cm_data;

    ovs_accum u_ovs_accum (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ratio(cfg_ratio),
        .cfg_shift(cfg_shift), .cfg_per_sample(cfg_per_sample), .trig_in(trig_in),
        .smp_valid(smp_valid), .smp_data(smp_data), .conv_req(conv_req),
        .avg_valid(avg_valid), .avg_data(avg_data)
    );

    // converter model: answers each request two cycles later
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            cm_valid = 1'b0;
            if (conv_req) begin
                repeat (2) @(negedge clk);
                cm_data  = force_max ? 12'hFFF : 12'($urandom);
                cm_valid = 1'b1;
                bsum    += longint'(cm_data);
                cm_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_req) req_cnt++;
            if (avg_valid) begin
                out_cnt++;
                last_out = avg_data;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_avg(input longint s, input int sh);
        int e = (sh > 8) ? 8 : sh;
        return (s >> e) & 64'hFFFF;
    endfunction

    task automatic wait_out();
        for (int t = 0; t < 4000 && out_cnt == 0; t++) @(negedge clk);
    endtask

    task automatic wait_smp(input int n);
        for (int t = 0; t < 100 && cm_cnt < n; t++) @(negedge clk);
    endtask

    task automatic run_burst(input int code, input int sh, input bit per,
                             input bit junk, input bit mess, input string tag);
        int n = 1 << (code + 1);
        @(negedge clk);
        cfg_ratio = 3'(code); cfg_shift = 4'(sh); cfg_per_sample = per; cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        bsum = 0; cm_cnt = 0; req_cnt = 0; out_cnt = 0;
        if (junk) begin // R9: stray sample while idle
            sp_data = 12'hFFF; sp_valid = 1'b1;
            @(negedge clk);
            sp_valid = 1'b0;
        end
        for (int i = 0; i < (per ? n : 1); i++) begin
            trig_in = 1'b1;
            @(negedge clk);
            trig_in = 1'b0;
            if (mess && i == 0) begin // R11
                cfg_ratio = 3'd7; cfg_shift = 4'd0; cfg_per_sample = ~per;
            end
            if (junk && i == 0) begin // R8: trigger while waiting
                trig_in = 1'b1;
                @(negedge clk);
                trig_in = 1'b0;
            end
            if (per) begin
                wait_smp(i + 1);
                repeat (3) @(negedge clk);
                if (junk && i < n - 1) begin // R9: stray sample in HOLD
                    sp_data = 12'hFFF; sp_valid = 1'b1;
                    @(negedge clk);
                    sp_valid = 1'b0;
                end
            end
        end
        wait_out();
        repeat (4) @(negedge clk);
        chk({tag, " R3 result count"}, out_cnt, 1);
        chk({tag, " R3 sample count"}, cm_cnt, n);
        chk(per ? {tag, " R7 request count"} : {tag, " R6 request count"}, req_cnt, n);
        chk({tag, " R4 average"}, last_out, expect_avg(bsum, sh));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 conv_req", conv_req, 0);
        chk("R1 avg_valid", avg_valid, 0);
        chk("R1 avg_data", avg_data, 0);

        // R2: pass-through with oversampling off
        bsum = 0; req_cnt = 0; out_cnt = 0;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk("R2 request latency", conv_req, 1);
        wait_out();
        chk("R2 pass count", out_cnt, 1);
        chk("R2 pass data", last_out, bsum);
        chk("R2 request count", req_cnt, 1);

        // directed runs
        run_burst(0, 1, 1'b0, 1'b0, 1'b0, "R6 burst x2");
        run_burst(1, 0, 1'b1, 1'b1, 1'b0, "R9 per-sample junk");
        run_burst(2, 3, 1'b0, 1'b1, 1'b0, "R8 burst retrig");
        force_max = 1'b1;
        run_burst(7, 0, 1'b0, 1'b0, 1'b0, "R5 full scale");
        chk("R5 truncated value", last_out, 65280);
        run_burst(2, 13, 1'b0, 1'b0, 1'b0, "R4 clamp");
        chk("R4 clamped shift", last_out, 127);
        force_max = 1'b0;
        run_burst(1, 1, 1'b0, 1'b0, 1'b1, "R11 snapshot");

        // R10: abort mid-run
        @(negedge clk);
        cfg_ratio = 3'd7; cfg_shift = 4'd0; cfg_per_sample = 1'b0; cfg_en = 1'b1;
        @(negedge clk);
        out_cnt = 0;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 no early result", out_cnt, 0);
        cfg_en = 1'b0;
        repeat (20) @(negedge clk);
        run_burst(1, 0, 1'b0, 1'b0, 1'b0, "R10 fresh run");

        // randomised runs
        for (int k = 0; k < 10; k++)
            run_burst(int'($urandom % 5), int'($urandom % 12), 1'($urandom),
                      1'($urandom), 1'b0, "R3 random");

        finish_run();
    end
endmodule